// File: doc/BRIEF.md
# Inverse-Mapping Frame Rotation Engine

This block builds a rotated copy of a frame held in external memory. It walks the destination frame in raster order. For each destination pixel it runs the inverse rotation, using signed fixed-point cosine and sine coefficients about the frame centre, to find the source pixel it needs. If that source pixel lies inside the frame, the engine issues a wide-word read, and the 16-bit lane it needs is picked out of the returned word. If the source pixel lies outside the frame, a zero pixel is used and no read is made.

Pixels land in an on-chip line buffer, in any order, as responses return. Once every pixel of a destination line is present, the line is written to the destination region as consecutive, fully aligned wide words. A single start pulse latches the coefficients and processes the whole frame. A one-cycle done pulse marks the end.

The read port tolerates variable and out-of-order response latency. Each request carries its destination column as a tag, and the engine bounds how many reads it keeps in flight.

Top module: `rot_engine`

## Requirements
- R1: Destination pixels (x, y) are processed row by row, left to right. With CX = W/2, CY = H/2, dx = x - CX, dy = y - CY, and coefficients c, s taken as signed 16-bit values with 14 fraction bits, the source is sx = CX + ((c*dx + s*dy + 8192) >>> 14) and sy = CY + ((c*dy - s*dx + 8192) >>> 14). Here >>> is an arithmetic right shift.
- R2: For an in-frame source pixel, the read word address is SRC_BASE + (sy*W + sx)/8. The request tag is the destination column x. The kept pixel is lane sx mod 8 of the 128-bit response, with lane j in bits 16j+15 down to 16j.
- R3: When sx or sy falls outside 0 to W-1 or 0 to H-1, no read is issued for that pixel, and the destination pixel is 0x0000.
- R4: No more than MAX_OUT (8) accepted reads are ever awaiting a response. Responses may return in any order and after any delay.
- R5: No destination write is presented while a read is pending or requested. A line is written only after all W of its pixels are in the line buffer.
- R6: Each destination line y goes out as W/8 writes of 128 bits. Word k goes to DST_BASE + y*W/8 + k and holds pixel x = 8k + j in lane j. Writes across the frame go to strictly consecutive addresses, and each is written exactly once.
- R7: Done is high for exactly one cycle. It comes after the final write of line H-1 is accepted. Afterwards no read or write is presented.
- R8: Start, and any coefficient change, is ignored while a frame is in progress.
- R9: A presented read request or write keeps its valid high and its address, tag and data unchanged until it is accepted.
- R10: After reset, done, the read request valid and the write valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; sampled only while idle |
| cos_coef | input | 16 | Signed cosine coefficient, 14 fraction bits |
| sin_coef | input | 16 | Signed sine coefficient, 14 fraction bits |
| rd_req_valid | output | 1 | Read request present |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Source word address |
| rd_req_tag | output | log2(W) | Destination column of the request |
| rd_rsp_valid | input | 1 | Read response present (always accepted) |
| rd_rsp_tag | input | log2(W) | Tag returned with the response |
| rd_rsp_data | input | DATA_W | Returned source word |
| wr_valid | output | 1 | Destination write present |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Destination word address |
| wr_data | output | DATA_W | Eight destination pixels |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench targets the cases where a rotation engine tends to break. At 90 and 180 degrees and at a near-2x scale, whole columns map outside the frame. An engine that reads anyway would show extra reads and non-zero edge pixels. At 45 and -30 degrees, rounding of negative products matters. Truncating instead of rounding shifts pixels by one position, and a wrong lane choice scrambles pixels within a word. Heavily out-of-order responses with throttled ready signals expose two faults: lane bookkeeping keyed by arrival order instead of tag, and flushing a line before its last pixel arrives. A start pulse with new coefficients in the middle of a frame exposes an engine that restarts or picks up the new angle.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int PIX_W     = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;

  typedef logic signed [COEF_W-1:0] coef_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FLUSH} eng_state_t;
  typedef enum logic [1:0] {FL_IDLE, FL_READ, FL_LOAD, FL_SEND} fl_state_t;
endpackage

// File: rtl/rot_coord_gen.sv
module rot_coord_gen
  import rot_pkg::*;
#(
  parameter int W = 1024,
  parameter int H = 1024,
  localparam int CW = $clog2(W),
  localparam int RW = $clog2(H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          adv,
  input  logic          nxt_row,
  input  coef_t         cos_in,
  input  coef_t         sin_in,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          col_active,
  output logic [CW-1:0] src_x,
  output logic [RW-1:0] src_y,
  output logic          in_bounds
);
  localparam int CX   = W / 2;
  localparam int CY   = H / 2;
  localparam int HALF = 1 << (COEF_FRAC - 1);

  coef_t c_q, s_q;
  logic  line_end_q;
  int    dx, dy, px, py, sx, sy;

  always_ff @(posedge clk) begin
    if (rst) begin
      col        <= '0;
      row        <= '0;
      line_end_q <= 1'b1;
      c_q        <= '0;
      s_q        <= '0;
    end else if (init) begin
      col        <= '0;
      row        <= '0;
      line_end_q <= 1'b0;
      c_q        <= cos_in;
      s_q        <= sin_in;
    end else if (nxt_row) begin
      col        <= '0;
      row        <= row + 1'b1;
      line_end_q <= 1'b0;
    end else if (adv) begin
      if (col == CW'(W - 1)) line_end_q <= 1'b1;
      else                   col        <= col + 1'b1;
    end
  end

  assign col_active = !line_end_q;

  always_comb begin
    dx = int'(col) - CX;
    dy = int'(row) - CY;
    px = int'(c_q) * dx + int'(s_q) * dy + HALF;
    py = int'(c_q) * dy - int'(s_q) * dx + HALF;
    sx = CX + (px >>> COEF_FRAC);
    sy = CY + (py >>> COEF_FRAC);
    in_bounds = (sx >= 0) && (sx < W) && (sy >= 0) && (sy < H);
    src_x = CW'(sx);
    src_y = RW'(sy);
  end
endmodule

// File: rtl/rot_line_buf.sv
module rot_line_buf
  import rot_pkg::*;
#(
  parameter int W     = 1024,
  parameter int LANES = 8,
  localparam int CW    = $clog2(W),
  localparam int LB    = $clog2(LANES),
  localparam int DEPTH = W / LANES,
  localparam int DW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [CW-1:0]          waddr,
  input  logic [PIX_W-1:0]       wdata,
  input  logic [DW-1:0]          raddr,
  output logic [LANES*PIX_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [PIX_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we && (waddr[LB-1:0] == LB'(g))) mem[waddr[CW-1:LB]] <= wdata;
      rd_q <= mem[raddr];
    end

    assign rdata[g*PIX_W +: PIX_W] = rd_q;
  end
endmodule

// File: rtl/rot_flush.sv
module rot_flush
  import rot_pkg::*;
#(
  parameter int W      = 1024,
  parameter int H      = 1024,
  parameter int LANES  = 8,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DST_BASE = '0,
  localparam int RW  = $clog2(H),
  localparam int WPL = W / LANES,
  localparam int DW  = $clog2(WPL)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic [RW-1:0]          row,
  output logic [DW-1:0]          lb_raddr,
  input  logic [LANES*PIX_W-1:0] lb_rdata,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [LANES*PIX_W-1:0] wr_data,
  output logic                   line_done
);
  fl_state_t     fst;
  logic [DW-1:0] widx;

  assign lb_raddr = widx;

  always_ff @(posedge clk) begin
    if (rst) begin
      fst       <= FL_IDLE;
      widx      <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      line_done <= 1'b0;
    end else begin
      line_done <= 1'b0;
      case (fst)
        FL_IDLE: if (go) begin
          widx <= '0;
          fst  <= FL_READ;
        end
        FL_READ: fst <= FL_LOAD;
        FL_LOAD: begin
          wr_data  <= lb_rdata;
          wr_addr  <= DST_BASE + ADDR_W'({row, widx});
          wr_valid <= 1'b1;
          fst      <= FL_SEND;
        end
        FL_SEND: if (wr_ready) begin
          wr_valid <= 1'b0;
          if (widx == DW'(WPL - 1)) begin
            line_done <= 1'b1;
            fst       <= FL_IDLE;
          end else begin
            widx <= widx + 1'b1;
            fst  <= FL_READ;
          end
        end
        default: fst <= FL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rot_engine.sv
module rot_engine
  import rot_pkg::*;
#(
  parameter int W       = 1024,
  parameter int H       = 1024,
  parameter int DATA_W  = 128,
  parameter int ADDR_W  = 32,
  parameter int MAX_OUT = 8,
  parameter logic [ADDR_W-1:0] SRC_BASE = '0,
  parameter logic [ADDR_W-1:0] DST_BASE = ADDR_W'(W * H * PIX_W / DATA_W),
  localparam int CW = $clog2(W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic signed [15:0] cos_coef,
  input  logic signed [15:0] sin_coef,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  output logic [CW-1:0]      rd_req_tag,
  input  logic               rd_rsp_valid,
  input  logic [CW-1:0]      rd_rsp_tag,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               done
);
  localparam int RW    = $clog2(H);
  localparam int LANES = DATA_W / PIX_W;
  localparam int LB    = $clog2(LANES);
  localparam int WPL   = W / LANES;
  localparam int DW    = $clog2(WPL);
  localparam int OW    = $clog2(MAX_OUT + 1);

  eng_state_t    st;
  logic [CW-1:0] col, src_x;
  logic [RW-1:0] row, src_y;
  logic          col_active, in_bounds;
  logic          init, issue, fill_we, adv, nxt_row, line_done, flush_go;
  logic [OW-1:0] outst;
  logic [CW:0]   filled;
  logic          line_full;

  logic              lb_we;
  logic [CW-1:0]     lb_waddr;
  logic [PIX_W-1:0]  lb_wdata, rsp_pix;
  logic [DW-1:0]     lb_raddr;
  logic [DATA_W-1:0] lb_rdata;

  logic [LB-1:0] lane_mem [W];
  logic [LB-1:0] rsp_lane;

  rot_coord_gen #(.W(W), .H(H)) u_coord (
    .clk(clk), .rst(rst), .init(init), .adv(adv), .nxt_row(nxt_row),
    .cos_in(cos_coef), .sin_in(sin_coef),
    .col(col), .row(row), .col_active(col_active),
    .src_x(src_x), .src_y(src_y), .in_bounds(in_bounds)
  );

  rot_line_buf #(.W(W), .LANES(LANES)) u_lbuf (
    .clk(clk), .we(lb_we), .waddr(lb_waddr), .wdata(lb_wdata),
    .raddr(lb_raddr), .rdata(lb_rdata)
  );

  rot_flush #(.W(W), .H(H), .LANES(LANES), .ADDR_W(ADDR_W), .DST_BASE(DST_BASE)) u_flush (
    .clk(clk), .rst(rst), .go(flush_go), .row(row),
    .lb_raddr(lb_raddr), .lb_rdata(lb_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_done(line_done)
  );

  // Scan control: a response owns the line-buffer port, a fill waits for it.
  always_comb begin
    init      = (st == ST_IDLE) && start;
    line_full = (filled == (CW+1)'(W));
    flush_go  = (st == ST_SCAN) && line_full;
    nxt_row   = (st == ST_FLUSH) && line_done && (row != RW'(H - 1));
    fill_we   = (st == ST_SCAN) && col_active && !in_bounds && !rd_rsp_valid;
    issue     = (st == ST_SCAN) && col_active && in_bounds &&
                (!rd_req_valid || rd_req_ready) && (outst < OW'(MAX_OUT));
    adv       = issue || fill_we;
  end

  // Lane picked from the response by the source column remembered per tag.
  always_ff @(posedge clk) begin
    if (issue) lane_mem[col] <= src_x[LB-1:0];
  end

  assign rsp_lane = lane_mem[rd_rsp_tag];

  always_comb begin
    rsp_pix = '0;
    for (int j = 0; j < LANES; j++)
      if (rsp_lane == LB'(j)) rsp_pix = rd_rsp_data[j*PIX_W +: PIX_W];
  end

  assign lb_we    = rd_rsp_valid || fill_we;
  assign lb_waddr = rd_rsp_valid ? rd_rsp_tag : col;
  assign lb_wdata = rd_rsp_valid ? rsp_pix : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      outst        <= '0;
      filled       <= '0;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      rd_req_tag   <= '0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE:  if (start) st <= ST_SCAN;
        ST_SCAN:  if (line_full) st <= ST_FLUSH;
        ST_FLUSH: if (line_done) begin
          if (row == RW'(H - 1)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st <= ST_SCAN;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (init || nxt_row) filled <= '0;
      else if (lb_we)      filled <= filled + 1'b1;

      case ({issue, rd_rsp_valid})
        2'b10:   outst <= outst + 1'b1;
        2'b01:   outst <= outst - 1'b1;
        default: outst <= outst;
      endcase

      if (issue) begin
        rd_req_valid <= 1'b1;
        rd_req_addr  <= SRC_BASE + ADDR_W'({src_y, src_x[CW-1:LB]});
        rd_req_tag   <= col;
      end else if (rd_req_ready) begin
        rd_req_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rot_engine_chk.sv
module rot_engine_chk #(
  parameter int W       = 1024,
  parameter int H       = 1024,
  parameter int DATA_W  = 128,
  parameter int ADDR_W  = 32,
  parameter int MAX_OUT = 8,
  parameter logic [ADDR_W-1:0] SRC_BASE = '0,
  parameter logic [ADDR_W-1:0] DST_BASE = '0,
  localparam int CW = $clog2(W)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic [CW-1:0]     rd_req_tag,
  input logic              rd_rsp_valid,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              done
);
  localparam int FW = W * H * 16 / DATA_W;
  localparam int AW = $clog2(MAX_OUT + 2) + 1;
  localparam logic [ADDR_W-1:0] SRC_END = SRC_BASE + ADDR_W'(FW);
  localparam logic [ADDR_W-1:0] DST_END = DST_BASE + ADDR_W'(FW);

  logic [AW-1:0] accepted;

  always_ff @(posedge clk) begin
    if (rst) accepted <= '0;
    else accepted <= accepted + AW'(rd_req_valid && rd_req_ready) - AW'(rd_rsp_valid);
  end

  AST_OUTSTANDING_CAP: assert property (@(posedge clk) disable iff (rst)
    accepted <= AW'(MAX_OUT)); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_tag)); // R9

  AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9

  AST_REQ_IN_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_req_addr >= SRC_BASE) && (rd_req_addr < SRC_END)); // R2

  AST_WR_IN_DEST: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr >= DST_BASE) && (wr_addr < DST_END)); // R6

  AST_FLUSH_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !rd_req_valid && (accepted == '0)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid && !rd_req_valid); // R7
endmodule

bind rot_engine rot_engine_chk #(
  .W(W), .H(H), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT),
  .SRC_BASE(SRC_BASE), .DST_BASE(DST_BASE)
) u_chk (.*);

// File: tb/rot_engine_tb.sv
module rot_engine_tb;
  localparam int W = 16, H = 16, L = 8, WPL = W / L, FW = W * H / L;
  localparam logic [31:0] SRC_B = 32'h40, DST_B = 32'h200;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic signed [15:0] cos_coef = '0, sin_coef = '0;
  logic rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [31:0] rd_req_addr, wr_addr;
  logic [3:0] rd_req_tag, rd_rsp_tag = '0;
  logic [127:0] rd_rsp_data = '0, wr_data;
  logic wr_valid, wr_ready = 1'b0, done;

  always #2.5 clk = ~clk;

  rot_engine #(.W(W), .H(H), .SRC_BASE(SRC_B), .DST_BASE(DST_B)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cos_coef(cos_coef), .sin_coef(sin_coef),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_tag(rd_req_tag), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_tag(rd_rsp_tag),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int rd_n, wr_n, done_n = 0, pend_n, max_pend;
  bit slow = 1'b0, finished = 1'b0;
  logic [15:0] lf = 16'hACE1;
  logic [127:0] dmem [FW];
  bit   p_v [16];
  int   p_addr [16], p_tag [16], p_dly [16];
  bit   req_stall = 1'b0, wr_stall = 1'b0;
  logic [31:0] st_raddr, st_waddr;
  logic [3:0]  st_tag;
  logic [127:0] st_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] src_pix(input int x, input int y);
    return 16'(32'hA000 + y * 64 + x);
  endfunction

  function automatic logic [127:0] src_word(input int a);
    int i = a - int'(SRC_B);
    logic [127:0] w = '1;
    if (i >= 0 && i < FW)
      for (int j = 0; j < L; j++) w[j*16 +: 16] = src_pix((i * L) % W + j, (i * L) / W);
    return w;
  endfunction

  // R1/R3: expected destination pixel from the inverse rotation
  function automatic logic [15:0] exp_pix(input int x, input int y, input int c, input int s,
                                          output bit inb);
    int dx = x - W / 2, dy = y - H / 2;
    int sx = W / 2 + ((c * dx + s * dy + 8192) >>> 14);
    int sy = H / 2 + ((c * dy - s * dx + 8192) >>> 14);
    inb = (sx >= 0) && (sx < W) && (sy >= 0) && (sy < H);
    return inb ? src_pix(sx, sy) : 16'h0000;
  endfunction

  task automatic model_step();
    bit got = 1'b0;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    // R9 hold checks for stalls seen at the previous edge
    if (req_stall) chk(rd_req_valid && rd_req_addr == st_raddr && rd_req_tag == st_tag,
                       "R9", "read request held", {rd_req_valid, rd_req_addr}, {1'b1, st_raddr});
    if (wr_stall) chk(wr_valid && wr_addr == st_waddr && wr_data == st_wdata,
                      "R9", "write held", wr_data, st_wdata);
    rd_rsp_valid = 1'b0;
    for (int n = 0; n < 16; n++) begin
      int k = (n + int'(lf[3:0])) % 16;
      if (!got && p_v[k] && p_dly[k] <= 0) begin
        got = 1'b1;
        p_v[k] = 1'b0;
        pend_n--;
        rd_rsp_valid = 1'b1;
        rd_rsp_tag = 4'(p_tag[k]);
        rd_rsp_data = src_word(p_addr[k]);
      end
    end
    for (int k = 0; k < 16; k++) if (p_v[k]) p_dly[k]--;
    rd_req_ready = slow ? (lf[5] | lf[6]) : 1'b1;
    if (rd_req_valid && rd_req_ready) begin
      got = 1'b0;
      for (int k = 0; k < 16; k++)
        if (!got && !p_v[k]) begin
          got = 1'b1;
          p_v[k] = 1'b1;
          p_addr[k] = int'(rd_req_addr);
          p_tag[k] = int'(rd_req_tag);
          p_dly[k] = slow ? int'(lf[11:7]) : int'(lf[1:0]);
        end
      rd_n++;
      pend_n++;
      if (pend_n > max_pend) max_pend = pend_n;
    end
    req_stall = rd_req_valid && !rd_req_ready;
    st_raddr = rd_req_addr;
    st_tag = rd_req_tag;
    wr_ready = slow ? (lf[12] | lf[14]) : 1'b1;
    if (wr_valid && wr_ready) begin
      chk(wr_addr == DST_B + 32'(wr_n), "R6", "write address order", wr_addr, DST_B + 32'(wr_n));
      chk(pend_n == 0 && !rd_req_valid, "R5", "write with reads pending", pend_n, 0);
      if (wr_addr >= DST_B && wr_addr < DST_B + FW) dmem[wr_addr - DST_B] = wr_data;
      wr_n++;
    end
    wr_stall = wr_valid && !wr_ready;
    st_waddr = wr_addr;
    st_wdata = wr_data;
    if (done) done_n++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) model_step();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog: done actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_frame(input string name, input int c, input int s,
                           input bit slow_mode, input bit probe);
    int d0 = done_n, exp_rd = 0;
    bit inb;
    logic [127:0] ew;
    slow = slow_mode;
    rd_n = 0; wr_n = 0; pend_n = 0; max_pend = 0;
    for (int i = 0; i < FW; i++) dmem[i] = {8{16'hDEAD}};
    @(negedge clk);
    start = 1'b1; cos_coef = 16'(c); sin_coef = 16'(s);
    @(negedge clk);
    start = 1'b0;
    if (probe) begin
      // R8: a second start with other coefficients mid-frame must change nothing
      repeat (40) @(negedge clk);
      start = 1'b1; cos_coef = 16'sd16384; sin_coef = 16'sd0;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_n == d0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(done_n - d0 == 1, "R7", {name, " done pulses"}, done_n - d0, 1);
    chk(!rd_req_valid && !wr_valid, "R7", {name, " quiet after done"}, {rd_req_valid, wr_valid}, 0);
    chk(wr_n == FW, "R6", {name, " write count"}, wr_n, FW);
    chk(max_pend <= 8, "R4", {name, " outstanding reads"}, max_pend, 8);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        void'(exp_pix(x, y, c, s, inb));
        if (inb) exp_rd++;
      end
    chk(rd_n == exp_rd, "R3", {name, " reads issued"}, rd_n, exp_rd);
    for (int i = 0; i < FW; i++) begin
      for (int j = 0; j < L; j++) ew[j*16 +: 16] = exp_pix((i % WPL) * L + j, i / WPL, c, s, inb);
      chk(dmem[i] == ew, probe ? "R8" : "R1", {name, " destination word (R2)"}, dmem[i], ew);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !rd_req_valid && !wr_valid, "R10", "reset outputs",
        {done, rd_req_valid, wr_valid}, 0);
    run_frame("identity", 16384, 0, 1'b0, 1'b0);
    run_frame("rot90", 0, 16384, 1'b1, 1'b0);
    run_frame("rot180", -16384, 0, 1'b1, 1'b0);
    run_frame("rot45", 11585, 11585, 1'b1, 1'b0);
    run_frame("rotm30", 14189, -8192, 1'b0, 1'b0);
    run_frame("scale2", 32767, 0, 1'b1, 1'b0);
    run_frame("restart", 0, 16384, 1'b0, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule